// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block decides when a network transceiver is held in reset and when it may work again. Three requests can put it into reset. The first is a power-good input that starts a fixed power-on interval. The second is an asynchronous active-low reset pin, which only counts after it has stayed low for several cycles. The third is a write to control register 0 that sets its bit 15. At the end of every reset the block gives a one-cycle strobe that loads the register defaults.

Release takes two steps. After a fixed number of reference-clock cycles the management port is reported ready. The datapath is reported ready only once the transmit and receive clocks are reported valid. A timeout flag shows that the clocks have taken longer than a parameterised limit to appear. All durations are counted in reference-clock cycles and are parameters, so a simulation can use short values. The defaults are 5 cycles to qualify the pin, 16 cycles of exit, 500 cycles of power-on hold and a wait limit of 1,325,000 cycles.

Top module: `multi_reset_seq`

## Requirements
- R1: A reset from the pin starts only when the synchronised pin has been low for HW_QUAL (5) consecutive cycles. A shorter low pulse changes no output.
- R2: The pin passes through a two-flop synchronizer. `mgmt_ready` rises on the clock edge 2 + EXIT_CYCLES (18) edges after the first edge that samples the pin high again.
- R3: While `pwr_good` is low, all outputs are 0. After `pwr_good` is first sampled high, the block holds reset for POR_CYCLES edges and then runs the exit sequence, so `mgmt_ready` rises POR_CYCLES + EXIT_CYCLES edges after that first high sample.
- R4: `dp_ready` is 1 only while `mgmt_ready` and `clk_valid` are both 1. In the waiting phase it rises one edge after `clk_valid` is sampled high. It falls in the same cycle that `clk_valid` falls.
- R5: `clk_timeout` rises once WAIT_LIMIT edges have passed in the waiting phase without `clk_valid`. It clears when the datapath becomes ready or a new reset starts.
- R6: The pin is ignored during the power-on interval. A low pulse on the pin during that interval neither extends nor repeats it.
- R7: A write (`ctl_wr_en`=1) with `ctl_wr_rst`=1, which is the value of register 0 bit 15, starts a software reset. A write with `ctl_wr_rst`=0 has no effect.
- R8: `ctl_rst_bit` reads 1 only in the cycle after an accepted software-reset write. It is 0 otherwise, and a pin reset or power-on reset never sets it.
- R9: `load_defaults` is a single-cycle pulse at the end of every reset, whether from the pin, software or power-on. It comes on the edge where the exit count begins.
- R10: A new request from the pin or from software during an exit or wait restarts the whole sequence. `mgmt_ready` and `dp_ready` are both 0 from the next edge.
- R11: A software reset with the pin high holds reset for one edge, so `mgmt_ready` returns EXIT_CYCLES + 2 edges after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_good | input | 1 | Supply above minimum; low acts as synchronous reset and power-on trigger |
| hw_rst_n | input | 1 | Asynchronous active-low reset pin |
| ctl_wr_en | input | 1 | Write strobe for control register 0 |
| ctl_wr_rst | input | 1 | Value written to register 0 bit 15 |
| clk_valid | input | 1 | Transmit and receive clocks reported valid |
| load_defaults | output | 1 | One-cycle strobe that loads register defaults |
| mgmt_ready | output | 1 | Management port usable |
| dp_ready | output | 1 | Datapath interface usable |
| clk_timeout | output | 1 | Clock-valid wait exceeded its limit |
| ctl_rst_bit | output | 1 | Readback of the self-clearing register 0 bit 15 |

## Verification
Some properties are checked on every cycle by the assertions. A pin request never follows fewer than two low samples. The power-on interval is never left for the hold state. The datapath is never reported ready without valid clocks and management ready. The default strobe never lasts two cycles. Any accepted request drops management ready on the next edge.

Other behaviour only shows up in the bench scenarios, where a cycle model runs alongside the block: the exact 18-edge and POR_CYCLES + 16-edge release latencies, the fact that a four-cycle pulse leaves everything untouched, the restart when a pin reset arrives in the middle of an exit, and the moment the timeout rises.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_POR  = 3'd0,
        ST_HOLD = 3'd1,
        ST_EXIT = 3'd2,
        ST_WAIT = 3'd3,
        ST_RUN  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic hw;
        logic sw;
    } rst_req_t;

    function automatic logic mgmt_up(input seq_state_e s);
        return (s == ST_WAIT) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
    parameter int HW_QUAL = 5
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic in_por,
    input  logic pin_n,
    output logic pin_s,
    output logic hw_req
);
    localparam int CW = $clog2(HW_QUAL + 1);
    localparam logic [CW-1:0] LAST = CW'(HW_QUAL - 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            low_cnt <= '0;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
            if (in_por || s2_q)
                low_cnt <= '0;
            else if (low_cnt != LAST)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    assign pin_s  = s2_q;
    assign hw_req = !in_por && !s2_q && (low_cnt == LAST);

    a_r1_qualified_low: assert property (@(posedge clk) disable iff (!pwr_good)
        hw_req |-> $past(!s2_q));

endmodule

// File: rtl/rst_sw_ctl.sv
module rst_sw_ctl (
    input  logic clk,
    input  logic pwr_good,
    input  logic in_por,
    input  logic wr_en,
    input  logic wr_rst,
    output logic sw_req,
    output logic bit_q
);
    assign sw_req = wr_en && wr_rst && !in_por;

    always_ff @(posedge clk) begin
        if (!pwr_good)
            bit_q <= 1'b0;
        else
            bit_q <= sw_req;
    end

    a_r8_bit_only_after_write: assert property (@(posedge clk) disable iff (!pwr_good)
        bit_q |-> $past(wr_en && wr_rst));

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int POR_CYCLES  = 500,
    parameter int EXIT_CYCLES = 16,
    parameter int WAIT_LIMIT  = 1325000
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  rst_req_t   req,
    input  logic       pin_s,
    input  logic       clk_valid,
    output logic       in_por,
    output logic       load_defaults,
    output logic       mgmt_ready,
    output logic       dp_ready,
    output logic       clk_timeout
);
    localparam int PW = $clog2(POR_CYCLES + 1);
    localparam int EW = $clog2(EXIT_CYCLES + 1);
    localparam int WW = $clog2(WAIT_LIMIT + 1);

    seq_state_e    state;
    logic [PW-1:0] por_cnt;
    logic [EW-1:0] exit_cnt;
    logic [WW-1:0] wait_cnt;
    logic          ld_q, tmo_q;

    always_ff @(posedge clk) begin
        if (!pwr_good) begin
            state    <= ST_POR;
            por_cnt  <= '0;
            exit_cnt <= '0;
            wait_cnt <= '0;
            ld_q     <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            ld_q <= 1'b0;
            if (state == ST_POR) begin
                if (por_cnt == PW'(POR_CYCLES - 1)) begin
                    state    <= ST_EXIT;
                    exit_cnt <= '0;
                    ld_q     <= 1'b1;
                end else begin
                    por_cnt <= por_cnt + 1'b1;
                end
            end else if (req.hw || req.sw) begin
                state    <= ST_HOLD;
                wait_cnt <= '0;
                tmo_q    <= 1'b0;
            end else begin
                case (state)
                    ST_HOLD: if (pin_s) begin
                        state    <= ST_EXIT;
                        exit_cnt <= '0;
                        ld_q     <= 1'b1;
                    end
                    ST_EXIT: if (exit_cnt == EW'(EXIT_CYCLES - 1)) begin
                        state    <= ST_WAIT;
                        wait_cnt <= '0;
                    end else begin
                        exit_cnt <= exit_cnt + 1'b1;
                    end
                    ST_WAIT: if (clk_valid) begin
                        state <= ST_RUN;
                        tmo_q <= 1'b0;
                    end else if (!tmo_q) begin
                        if (wait_cnt == WW'(WAIT_LIMIT - 1))
                            tmo_q <= 1'b1;
                        else
                            wait_cnt <= wait_cnt + 1'b1;
                    end
                    ST_RUN: if (!clk_valid) begin
                        state    <= ST_WAIT;
                        wait_cnt <= '0;
                    end
                    default: state <= ST_POR;
                endcase
            end
        end
    end

    assign in_por        = (state == ST_POR);
    assign load_defaults = ld_q;
    assign mgmt_ready    = mgmt_up(state);
    assign dp_ready      = (state == ST_RUN) && clk_valid;
    assign clk_timeout   = tmo_q;

    a_r6_por_not_to_hold: assert property (@(posedge clk) disable iff (!pwr_good)
        $past(state == ST_POR) |-> (state == ST_POR || state == ST_EXIT));

    a_r2_ready_after_exit_count: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(mgmt_ready) |-> ($past(state == ST_EXIT) && $past(exit_cnt) == EW'(EXIT_CYCLES - 1)));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!pwr_good)
        load_defaults |=> !load_defaults);

    a_r7_sw_enters_hold: assert property (@(posedge clk) disable iff (!pwr_good)
        req.sw |=> (state == ST_HOLD));

    a_r10_restart_drops_ready: assert property (@(posedge clk) disable iff (!pwr_good)
        ((req.hw || req.sw) && !in_por) |=> (!mgmt_ready && !dp_ready));

endmodule

// File: rtl/multi_reset_seq.sv
module multi_reset_seq
    import rst_seq_pkg::*;
#(
    parameter int HW_QUAL     = 5,
    parameter int EXIT_CYCLES = 16,
    parameter int POR_CYCLES  = 500,
    parameter int WAIT_LIMIT  = 1325000
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic hw_rst_n,
    input  logic ctl_wr_en,
    input  logic ctl_wr_rst,
    input  logic clk_valid,
    output logic load_defaults,
    output logic mgmt_ready,
    output logic dp_ready,
    output logic clk_timeout,
    output logic ctl_rst_bit
);
    rst_req_t req;
    logic     pin_s, in_por;

    rst_pin_qual #(.HW_QUAL(HW_QUAL)) u_pin (
        .clk      (clk),
        .pwr_good (pwr_good),
        .in_por   (in_por),
        .pin_n    (hw_rst_n),
        .pin_s    (pin_s),
        .hw_req   (req.hw)
    );

    rst_sw_ctl u_sw (
        .clk      (clk),
        .pwr_good (pwr_good),
        .in_por   (in_por),
        .wr_en    (ctl_wr_en),
        .wr_rst   (ctl_wr_rst),
        .sw_req   (req.sw),
        .bit_q    (ctl_rst_bit)
    );

    rst_seq_fsm #(
        .POR_CYCLES  (POR_CYCLES),
        .EXIT_CYCLES (EXIT_CYCLES),
        .WAIT_LIMIT  (WAIT_LIMIT)
    ) u_fsm (
        .clk           (clk),
        .pwr_good      (pwr_good),
        .req           (req),
        .pin_s         (pin_s),
        .clk_valid     (clk_valid),
        .in_por        (in_por),
        .load_defaults (load_defaults),
        .mgmt_ready    (mgmt_ready),
        .dp_ready      (dp_ready),
        .clk_timeout   (clk_timeout)
    );

    a_r4_dp_needs_clocks: assert property (@(posedge clk) disable iff (!pwr_good)
        dp_ready |-> (clk_valid && mgmt_ready));

    a_r5_timeout_only_waiting: assert property (@(posedge clk) disable iff (!pwr_good)
        clk_timeout |-> (mgmt_ready && !dp_ready));

endmodule

// File: tb/tb_multi_reset_seq.sv
module tb_multi_reset_seq;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 5;
    localparam int EXITC = 16;
    localparam int PORC = 40;
    localparam int WLIM = 60;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, hw_rst_n = 1'b1, ctl_wr_en = 1'b0, ctl_wr_rst = 1'b0, clk_valid = 1'b0;
    logic load_defaults, mgmt_ready, dp_ready, clk_timeout, ctl_rst_bit;

    int checks = 0, fails = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    multi_reset_seq #(.HW_QUAL(QUAL), .EXIT_CYCLES(EXITC), .POR_CYCLES(PORC), .WAIT_LIMIT(WLIM)) dut (
        .clk(clk), .pwr_good(pwr_good), .hw_rst_n(hw_rst_n), .ctl_wr_en(ctl_wr_en),
        .ctl_wr_rst(ctl_wr_rst), .clk_valid(clk_valid), .load_defaults(load_defaults),
        .mgmt_ready(mgmt_ready), .dp_ready(dp_ready), .clk_timeout(clk_timeout),
        .ctl_rst_bit(ctl_rst_bit));

    // behavioural reference: phase names as integers
    localparam int P_POR = 0, P_HOLD = 1, P_EXIT = 2, P_WAIT = 3, P_RUN = 4;
    int m_phase = P_POR, m_cnt = 0, m_low = 0, m_wait = 0;
    bit m_ld = 0, m_bit = 0, m_tmo = 0;
    bit sync_q[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        if (!pwr_good) begin
            m_phase = P_POR; m_cnt = 0; m_low = 0; m_wait = 0;
            m_ld = 0; m_bit = 0; m_tmo = 0;
            sync_q = '{1'b1, 1'b1};
        end else begin
            bit s2, por, hwq, swq;
            s2  = sync_q[0];
            por = (m_phase == P_POR);
            hwq = !por && !s2 && (m_low + 1 >= QUAL);
            swq = !por && ctl_wr_en && ctl_wr_rst;
            m_low = (por || s2) ? 0 : ((m_low + 1 > QUAL) ? QUAL : m_low + 1);
            m_bit = swq;
            m_ld = 0;
            if (por) begin
                if (m_cnt == PORC - 1) begin m_phase = P_EXIT; m_cnt = 0; m_ld = 1; end
                else m_cnt++;
            end else if (hwq || swq) begin
                m_phase = P_HOLD; m_wait = 0; m_tmo = 0;
            end else if (m_phase == P_HOLD) begin
                if (s2) begin m_phase = P_EXIT; m_cnt = 0; m_ld = 1; end
            end else if (m_phase == P_EXIT) begin
                if (m_cnt == EXITC - 1) begin m_phase = P_WAIT; m_wait = 0; end
                else m_cnt++;
            end else if (m_phase == P_WAIT) begin
                if (clk_valid) begin m_phase = P_RUN; m_tmo = 0; end
                else if (!m_tmo) begin
                    if (m_wait == WLIM - 1) m_tmo = 1; else m_wait++;
                end
            end else if (m_phase == P_RUN) begin
                if (!clk_valid) begin m_phase = P_WAIT; m_wait = 0; end
            end
            void'(sync_q.pop_front());
            sync_q.push_back(hw_rst_n);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            bit e_mg, e_dp;
            e_mg = (m_phase == P_WAIT) || (m_phase == P_RUN);
            e_dp = (m_phase == P_RUN) && clk_valid;
            check(mgmt_ready == e_mg, "R2 mgmt_ready", mgmt_ready, e_mg);
            check(dp_ready == e_dp, "R4 dp_ready", dp_ready, e_dp);
            check(load_defaults == m_ld, "R9 load_defaults", load_defaults, m_ld);
            check(ctl_rst_bit == m_bit, "R8 ctl_rst_bit", ctl_rst_bit, m_bit);
            check(clk_timeout == m_tmo, "R5 clk_timeout", clk_timeout, m_tmo);
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // pin low for n sampled edges, then high; returns edges to mgmt_ready rise
    task automatic pin_pulse(input int n, output int lat, output bit stayed_low);
        hw_rst_n = 1'b0;
        repeat (n) tick();
        hw_rst_n = 1'b1;
        lat = 0; stayed_low = 0;
        for (int i = 0; i < 60; i++) begin
            tick(); lat++;
            if (!mgmt_ready) stayed_low = 1;
            if (mgmt_ready && stayed_low) break;
        end
    endtask

    initial begin
        int n; bit low_seen; bit stay1;
        repeat (3) tick();
        cmp_en = 1'b1;
        repeat (3) tick();
        // R3 reset state
        check(!mgmt_ready && !dp_ready && !load_defaults && !clk_timeout && !ctl_rst_bit,
              "R3 outputs low under pwr_good low", mgmt_ready, 0);

        // R3 / R6 power-on with a pin pulse inside the interval
        pwr_good = 1'b1; hw_rst_n = 1'b0;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            tick(); n++;
            if (n == 20) hw_rst_n = 1'b1;
            if (mgmt_ready) break;
        end
        check(n == PORC + EXITC, "R3 R6 power-on release latency", n, PORC + EXITC);

        // R4 datapath ready
        repeat (4) tick();
        check(!dp_ready, "R4 dp low without clk_valid", dp_ready, 0);
        clk_valid = 1'b1; #1;
        check(!dp_ready, "R4 dp not immediate", dp_ready, 0);
        tick();
        check(dp_ready, "R4 dp after clk_valid", dp_ready, 1);

        // R1 short pulse ignored
        hw_rst_n = 1'b0;
        repeat (QUAL - 1) tick();
        hw_rst_n = 1'b1;
        stay1 = 1;
        repeat (12) begin tick(); if (!mgmt_ready || !dp_ready || load_defaults) stay1 = 0; end
        check(stay1, "R1 four-cycle pulse ignored", stay1, 1);

        // R1 / R2 qualified pulse
        pin_pulse(QUAL, n, low_seen);
        check(low_seen, "R1 five-cycle pulse resets", low_seen, 1);
        check(n == EXITC + 3, "R2 release latency", n, EXITC + 3);
        tick();
        check(dp_ready, "R4 dp back after reset", dp_ready, 1);

        // R7 write without bit 15
        ctl_wr_en = 1'b1; ctl_wr_rst = 1'b0; tick(); ctl_wr_en = 1'b0;
        check(mgmt_ready && !ctl_rst_bit, "R7 write bit15=0 no effect", mgmt_ready, 1);
        tick();
        check(mgmt_ready && dp_ready, "R7 still ready", dp_ready, 1);

        // R7 / R8 / R11 software reset
        ctl_wr_en = 1'b1; ctl_wr_rst = 1'b1; tick(); ctl_wr_en = 1'b0; ctl_wr_rst = 1'b0;
        n = 1;
        check(ctl_rst_bit, "R8 bit reads 1 after write", ctl_rst_bit, 1);
        check(!mgmt_ready && !dp_ready, "R7 sw reset drops ready", mgmt_ready, 0);
        tick(); n++;
        check(!ctl_rst_bit, "R8 bit self-clears", ctl_rst_bit, 0);
        check(load_defaults, "R9 defaults strobe after sw reset", load_defaults, 1);
        for (int i = 0; i < 40 && !mgmt_ready; i++) begin tick(); n++; end
        check(n == EXITC + 2, "R11 sw release latency", n, EXITC + 2);

        // R10 restart during exit
        repeat (3) tick();
        ctl_wr_en = 1'b1; ctl_wr_rst = 1'b1; tick(); ctl_wr_en = 1'b0; ctl_wr_rst = 1'b0;
        repeat (3) tick();
        check(!mgmt_ready, "R10 in exit", mgmt_ready, 0);
        pin_pulse(QUAL, n, low_seen);
        check(n == EXITC + 3, "R10 restart latency", n, EXITC + 3);
        check(!ctl_rst_bit, "R8 bit not set by pin reset", ctl_rst_bit, 0);

        // R5 timeout and R4 immediate drop
        repeat (3) tick();
        clk_valid = 1'b0; #1;
        check(!dp_ready, "R4 dp drops with clk_valid", dp_ready, 0);
        n = 0;
        repeat (WLIM - 2) begin tick(); n++; end
        check(!clk_timeout, "R5 no timeout early", clk_timeout, 0);
        repeat (4) begin tick(); n++; end
        check(clk_timeout, "R5 timeout raised", clk_timeout, 1);
        clk_valid = 1'b1; tick(); tick();
        check(!clk_timeout && dp_ready, "R5 timeout cleared", clk_timeout, 0);

        // R3 power loss
        pwr_good = 1'b0; tick();
        check(!mgmt_ready && !dp_ready && !clk_timeout, "R3 power loss clears", mgmt_ready, 0);
        tick();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

endmodule